// File: doc/BRIEF.md
# Run-Length Image Decompression Engine

The engine expands a run-length-encoded image into raw pixels. Compressed data is written as 64-bit words into an eight-entry input queue. A byte-serial parser reads tokens from that queue. Each run is expanded one pixel per cycle and tagged with its column and row. Pixels inside a programmed rectangle are packed into 64-bit words, which are pushed into an eight-entry output queue for a bus master or DMA channel to read.

Before each image, software sets the image size, the pixel format and the window, then pulses `cfg_start`. This pulse latches the settings and clears the queues, counters and flags. Decoding then starts as soon as the input queue holds data. It ends when exactly width × height pixels have been produced. If a run would pass the end of the image, decoding stops with an error. The two DMA request lines are driven by comparing each queue's level with a threshold, so that burst transfers can be started.

Top module: `rle_unpack_engine`

## Requirements
- R1: `cfg_pix_fmt` selects the pixel size: code 0 = 1 byte, 1 = 2 bytes, 2 = 3 bytes, 3 = 4 bytes.
- R2: A token is a count byte N followed by the pixel value (least significant byte first), and it produces N+1 copies of that pixel. Bytes are taken from each input word starting at bits 7:0 and moving upward.
- R3: Decoding needs no trigger other than data in the input queue after `cfg_start`. It pauses without losing or repeating data while the input queue is empty or the output queue is full.
- R4: Pixels are numbered in row-major order. The column wraps at the image width. A pixel is output only if its column is in [`cfg_col_first`, `cfg_col_last`] and its row is in [`cfg_row_first`, `cfg_row_last`] (both bounds inclusive).
- R5: Kept pixels are packed least significant byte first, continuing across word boundaries. When the image is complete, a final partly filled word is zero-padded and pushed.
- R6: `done_irq` goes high and stays high once exactly width × height pixels have been decoded and the last word has been pushed. Input that follows the last token is not consumed.
- R7: If a run would go past the last pixel of the image, `err_irq` goes high and no pixel of that run is output. Any partly packed word is dropped, decoding stops, and `done_irq` stays low.
- R8: Each queue holds 8 words of 64 bits. `in_full` is high at 8 entries. `out_rd_data` shows the oldest output word whenever `out_empty` is low.
- R9: `in_dma_req` is high while the input queue level is ≤ `in_dma_level`. `out_dma_req` is high while the output queue level is ≥ `out_dma_level`.
- R10: `cfg_start` empties both queues and clears `done_irq` and `err_irq`. Settings are captured at that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Latch settings and begin a new image |
| cfg_width | input | 16 | Image width in pixels |
| cfg_height | input | 16 | Image height in pixels |
| cfg_pix_fmt | input | 2 | Pixel size code |
| cfg_col_first | input | 16 | First column of output window |
| cfg_col_last | input | 16 | Last column of output window |
| cfg_row_first | input | 16 | First row of output window |
| cfg_row_last | input | 16 | Last row of output window |
| in_dma_level | input | 4 | Input request threshold |
| out_dma_level | input | 4 | Output request threshold |
| in_wr_en | input | 1 | Write strobe, input queue |
| in_wr_data | input | 64 | Compressed data word |
| in_full | output | 1 | Input queue full |
| in_dma_req | output | 1 | Input refill request |
| out_rd_en | input | 1 | Read strobe, output queue |
| out_rd_data | output | 64 | Oldest decoded word |
| out_empty | output | 1 | Output queue empty |
| out_dma_req | output | 1 | Output drain request |
| done_irq | output | 1 | Image completed |
| err_irq | output | 1 | Run overran the image |

## Verification
The assertions assume that nothing writes to the input queue while `in_full` is high and that width and height are never zero. They also assume that every token stream either reaches the end of the image or triggers the overrun, so that zero padding in the last word is never decoded as pixels. The bench writes only when `in_full` is low and stops writing once either interrupt is set. It programs only non-zero dimensions and builds each stream so that its tokens fill the image exactly or overrun it on purpose.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int WORD_W = 64;
    localparam int DIM_W  = 16;
    localparam int PIX_W  = 32;

    typedef enum logic [1:0] {
        FMT_1B = 2'd0,
        FMT_2B = 2'd1,
        FMT_3B = 2'd2,
        FMT_4B = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
        pix_fmt_e         fmt;
        logic [DIM_W-1:0] col_lo;
        logic [DIM_W-1:0] col_hi;
        logic [DIM_W-1:0] row_lo;
        logic [DIM_W-1:0] row_hi;
    } img_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_VALUE,
        ST_RUN,
        ST_END,
        ST_ERR
    } dec_state_e;

    typedef struct packed {
        logic             valid;
        logic             keep;
        logic             last;
        logic [PIX_W-1:0] value;
    } pix_beat_t;

    function automatic logic [2:0] fmt_bytes(pix_fmt_e f);
        return 3'(f) + 3'd1;
    endfunction
endpackage

// File: rtl/rle_fifo.sv
module rle_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [LW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == LW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign level   = cnt_q;
    assign head    = mem[rp_q];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + LW'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - LW'(1);
        end
    end

    // R8
    fifo_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && push && !full && !pop) |=> level == $past(level) + LW'(1));
endmodule

// File: rtl/rle_decoder.sv
module rle_decoder
    import rle_pkg::*;
#(
    parameter int WORD_W_P = WORD_W,
    localparam int BIDX_W  = $clog2(WORD_W_P / 8)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  img_cfg_t            cfg,
    input  logic [WORD_W_P-1:0] in_word,
    input  logic                in_avail,
    output logic                in_pop,
    input  logic                out_ready,
    output pix_beat_t           beat,
    output logic [2:0]          nbytes,
    output logic                err
);
    img_cfg_t         cfg_q;
    dec_state_e       st_q;
    logic [BIDX_W-1:0] bidx_q;
    logic [7:0]       cnt_q, rep_q;
    logic [PIX_W-1:0] val_q;
    logic [1:0]       vb_q;
    logic [31:0]      idx_q, total_q;
    logic [DIM_W-1:0] col_q, row_q;

    logic       take, emit, overrun, in_win, at_last;
    logic [7:0] cur_byte;

    assign nbytes   = fmt_bytes(cfg_q.fmt);
    assign take     = (st_q == ST_COUNT || st_q == ST_VALUE) && in_avail;
    assign cur_byte = in_word[{bidx_q, 3'b000} +: 8];
    assign in_pop   = take && (bidx_q == BIDX_W'(WORD_W_P / 8 - 1));
    assign emit     = (st_q == ST_RUN) && out_ready;
    assign overrun  = (idx_q + 32'(cnt_q)) >= total_q;
    assign at_last  = (idx_q == total_q - 32'd1);
    assign in_win   = (col_q >= cfg_q.col_lo) && (col_q <= cfg_q.col_hi) &&
                      (row_q >= cfg_q.row_lo) && (row_q <= cfg_q.row_hi);
    assign err      = (st_q == ST_ERR);

    always_comb begin
        beat.valid = emit;
        beat.keep  = emit && in_win;
        beat.last  = emit && at_last;
        beat.value = val_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            st_q    <= ST_IDLE;
            bidx_q  <= '0;
            cnt_q   <= '0;
            rep_q   <= '0;
            val_q   <= '0;
            vb_q    <= '0;
            idx_q   <= '0;
            total_q <= '0;
            col_q   <= '0;
            row_q   <= '0;
        end else if (start) begin
            cfg_q   <= cfg;
            total_q <= 32'(cfg.width) * 32'(cfg.height);
            st_q    <= ST_COUNT;
            bidx_q  <= '0;
            idx_q   <= '0;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            if (take) bidx_q <= bidx_q + BIDX_W'(1);
            case (st_q)
                ST_COUNT: if (in_avail) begin
                    cnt_q <= cur_byte;
                    val_q <= '0;
                    vb_q  <= '0;
                    st_q  <= ST_VALUE;
                end
                ST_VALUE: if (in_avail) begin
                    val_q[{vb_q, 3'b000} +: 8] <= cur_byte;
                    if (3'(vb_q) + 3'd1 == nbytes) begin
                        if (overrun) st_q <= ST_ERR;
                        else begin
                            rep_q <= cnt_q;
                            st_q  <= ST_RUN;
                        end
                    end else begin
                        vb_q <= vb_q + 2'd1;
                    end
                end
                ST_RUN: if (emit) begin
                    idx_q <= idx_q + 32'd1;
                    if (col_q == cfg_q.width - DIM_W'(1)) begin
                        col_q <= '0;
                        row_q <= row_q + DIM_W'(1);
                    end else begin
                        col_q <= col_q + DIM_W'(1);
                    end
                    rep_q <= rep_q - 8'd1;
                    if (rep_q == 8'd0) st_q <= at_last ? ST_END : ST_COUNT;
                end
                default: ;
            endcase
        end
    end

    // R7
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= total_q);

    // R6
    end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (beat.last && rep_q == 8'd0 && !start) |=> st_q == ST_END);
endmodule

// File: rtl/rle_packer.sv
module rle_packer
    import rle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  pix_beat_t         beat,
    input  logic [2:0]        nbytes,
    input  logic              out_full,
    output logic              ready,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              fin
);
    localparam int EXT_W = WORD_W + PIX_W;

    logic [WORD_W-1:0] buf_q;
    logic [2:0]        fill_q;
    logic              flush_q, fin_q;
    logic [EXT_W-1:0]  ext;
    logic [3:0]        sum;
    logic              acc, wraps;
    logic [2:0]        next_fill;

    assign ext       = {{PIX_W{1'b0}}, buf_q} |
                       ({{WORD_W{1'b0}}, beat.value} << {fill_q, 3'b000});
    assign sum       = {1'b0, fill_q} + {1'b0, nbytes};
    assign acc       = beat.valid && beat.keep;
    assign wraps     = acc && (sum >= 4'd8);
    assign next_fill = acc ? sum[2:0] : fill_q;
    assign ready     = !out_full && !flush_q;
    assign push      = wraps || (flush_q && !out_full);
    assign push_data = flush_q ? buf_q : ext[WORD_W-1:0];
    assign fin       = fin_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            buf_q   <= '0;
            fill_q  <= '0;
            flush_q <= 1'b0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (flush_q) begin
                if (!out_full) begin
                    flush_q <= 1'b0;
                    buf_q   <= '0;
                    fill_q  <= '0;
                    fin_q   <= 1'b1;
                end
            end else if (beat.valid) begin
                if (acc) begin
                    buf_q  <= wraps ? {{PIX_W{1'b0}}, ext[EXT_W-1:WORD_W]} : ext[WORD_W-1:0];
                    fill_q <= next_fill;
                end
                if (beat.last) begin
                    if (next_fill != 3'd0) flush_q <= 1'b1;
                    else                   fin_q   <= 1'b1;
                end
            end
        end
    end

    // R5
    fill_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !push && !clr && !beat.last) |=> fill_q == $past(fill_q) + $past(nbytes));

    // R3
    no_emit_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> !out_full);
endmodule

// File: rtl/rle_unpack_engine.sv
module rle_unpack_engine
    import rle_pkg::*;
#(
    parameter int QDEPTH = 8,
    localparam int LW = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_start,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [1:0]        cfg_pix_fmt,
    input  logic [DIM_W-1:0]  cfg_col_first,
    input  logic [DIM_W-1:0]  cfg_col_last,
    input  logic [DIM_W-1:0]  cfg_row_first,
    input  logic [DIM_W-1:0]  cfg_row_last,
    input  logic [LW-1:0]     in_dma_level,
    input  logic [LW-1:0]     out_dma_level,
    input  logic              in_wr_en,
    input  logic [WORD_W-1:0] in_wr_data,
    output logic              in_full,
    output logic              in_dma_req,
    input  logic              out_rd_en,
    output logic [WORD_W-1:0] out_rd_data,
    output logic              out_empty,
    output logic              out_dma_req,
    output logic              done_irq,
    output logic              err_irq
);
    img_cfg_t          cfg;
    logic [WORD_W-1:0] in_head, pk_data;
    logic [LW-1:0]     in_lvl, out_lvl;
    logic              in_empty, in_pop, out_full;
    logic              pk_ready, pk_push, pk_fin, dec_err;
    logic [2:0]        nbytes;
    pix_beat_t         beat;
    logic              done_q;

    always_comb begin
        cfg.width  = cfg_width;
        cfg.height = cfg_height;
        cfg.fmt    = pix_fmt_e'(cfg_pix_fmt);
        cfg.col_lo = cfg_col_first;
        cfg.col_hi = cfg_col_last;
        cfg.row_lo = cfg_row_first;
        cfg.row_hi = cfg_row_last;
    end

    rle_fifo #(.WIDTH(WORD_W), .DEPTH(QDEPTH)) u_in_q (
        .clk(clk), .rst(rst), .clr(cfg_start),
        .push(in_wr_en), .push_data(in_wr_data), .pop(in_pop),
        .head(in_head), .level(in_lvl), .full(in_full), .empty(in_empty)
    );

    rle_decoder u_dec (
        .clk(clk), .rst(rst), .start(cfg_start), .cfg(cfg),
        .in_word(in_head), .in_avail(!in_empty), .in_pop(in_pop),
        .out_ready(pk_ready), .beat(beat), .nbytes(nbytes), .err(dec_err)
    );

    rle_packer u_pack (
        .clk(clk), .rst(rst), .clr(cfg_start), .beat(beat), .nbytes(nbytes),
        .out_full(out_full), .ready(pk_ready), .push(pk_push),
        .push_data(pk_data), .fin(pk_fin)
    );

    rle_fifo #(.WIDTH(WORD_W), .DEPTH(QDEPTH)) u_out_q (
        .clk(clk), .rst(rst), .clr(cfg_start),
        .push(pk_push), .push_data(pk_data), .pop(out_rd_en),
        .head(out_rd_data), .level(out_lvl), .full(out_full), .empty(out_empty)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_start) done_q <= 1'b0;
        else if (pk_fin)      done_q <= 1'b1;
    end

    assign done_irq    = done_q;
    assign err_irq     = dec_err;
    assign in_dma_req  = (in_lvl <= in_dma_level);
    assign out_dma_req = (out_lvl >= out_dma_level);

    // R7
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_irq && err_irq));
endmodule

// File: tb/rle_unpack_engine_tb.sv
module rle_unpack_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_start = 1'b0;
    logic [15:0] cfg_width = '0, cfg_height = '0;
    logic [1:0]  cfg_pix_fmt = '0;
    logic [15:0] cfg_col_first = '0, cfg_col_last = '0, cfg_row_first = '0, cfg_row_last = '0;
    logic [3:0]  in_dma_level = 4'd2, out_dma_level = 4'd1;
    logic        in_wr_en = 1'b0;
    logic [63:0] in_wr_data = '0;
    logic        in_full, in_dma_req, out_rd_en, out_empty, out_dma_req, done_irq, err_irq;
    logic [63:0] out_rd_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int tok_cnt[$];
    longint tok_val[$];
    logic [63:0] in_words[$];
    logic [63:0] exp_words[$];
    bit exp_err;

    always #2 clk = ~clk;

    initial out_rd_en = 1'b0;

    rle_unpack_engine u_dut (
        .clk(clk), .rst(rst), .cfg_start(cfg_start),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_pix_fmt(cfg_pix_fmt),
        .cfg_col_first(cfg_col_first), .cfg_col_last(cfg_col_last),
        .cfg_row_first(cfg_row_first), .cfg_row_last(cfg_row_last),
        .in_dma_level(in_dma_level), .out_dma_level(out_dma_level),
        .in_wr_en(in_wr_en), .in_wr_data(in_wr_data),
        .in_full(in_full), .in_dma_req(in_dma_req),
        .out_rd_en(out_rd_en), .out_rd_data(out_rd_data), .out_empty(out_empty),
        .out_dma_req(out_dma_req), .done_irq(done_irq), .err_irq(err_irq)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: byte stream in, expected output words out.
    task automatic build_model(int w, int h, int fmt, int c0, int c1, int r0, int r1);
        byte unsigned ib[$];
        byte unsigned ob[$];
        int pb = fmt + 1;
        int total = w * h;
        int idx = 0;
        in_words.delete();
        exp_words.delete();
        exp_err = 0;
        foreach (tok_cnt[t]) begin
            ib.push_back(8'(tok_cnt[t]));
            for (int b = 0; b < pb; b++) ib.push_back(8'(tok_val[t] >> (8 * b)));
        end
        while (ib.size() % 8 != 0) ib.push_back(8'h00);
        for (int i = 0; i < ib.size(); i += 8) begin
            logic [63:0] wd = '0;
            for (int j = 0; j < 8; j++) wd[8*j +: 8] = ib[i+j];
            in_words.push_back(wd);
        end
        foreach (tok_cnt[t]) begin
            if (idx == total) break;
            if (idx + tok_cnt[t] >= total) begin
                exp_err = 1;
                break;
            end
            for (int r = 0; r <= tok_cnt[t]; r++) begin
                int col = idx % w;
                int row = idx / w;
                if (col >= c0 && col <= c1 && row >= r0 && row <= r1)
                    for (int b = 0; b < pb; b++) ob.push_back(8'(tok_val[t] >> (8 * b)));
                idx++;
            end
        end
        if (!exp_err) while (ob.size() % 8 != 0) ob.push_back(8'h00);
        for (int i = 0; i + 8 <= ob.size(); i += 8) begin
            logic [63:0] wd = '0;
            for (int j = 0; j < 8; j++) wd[8*j +: 8] = ob[i+j];
            exp_words.push_back(wd);
        end
    endtask

    task automatic run_image(string tag, int w, int h, int fmt, int c0, int c1, int r0, int r1,
                             bit hold, bit throttle, int othr);
        int nexp;
        build_model(w, h, fmt, c0, c1, r0, r1);
        nexp = exp_words.size();
        @(negedge clk);
        cfg_width = 16'(w); cfg_height = 16'(h); cfg_pix_fmt = 2'(fmt);
        cfg_col_first = 16'(c0); cfg_col_last = 16'(c1);
        cfg_row_first = 16'(r0); cfg_row_last = 16'(r1);
        out_dma_level = 4'(othr);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        // R10: flags and queues cleared by the start pulse
        chk(!done_irq && !err_irq, "R10", {tag, " flags after start"}, {done_irq, err_irq}, 0);
        chk(out_empty && !in_full, "R10", {tag, " queues after start"}, {out_empty, in_full}, 2);
        cfg_width = 16'hFFFF; cfg_pix_fmt = 2'd0;
        fork
            begin : writer
                int i = 0;
                while (i < in_words.size() && !(done_irq || err_irq)) begin
                    if (!in_full) begin
                        in_wr_en = 1'b1;
                        in_wr_data = in_words[i];
                        i++;
                    end else in_wr_en = 1'b0;
                    @(negedge clk);
                end
                in_wr_en = 1'b0;
            end
            begin : reader
                if (hold) begin
                    while (!(done_irq || err_irq)) @(negedge clk);
                    // R9: output level is nexp with no reads done
                    chk(out_dma_req == (nexp >= othr), "R9", {tag, " out_dma_req"}, out_dma_req, nexp >= othr);
                end
                forever begin
                    if (out_empty) begin
                        out_rd_en = 1'b0;
                        if (done_irq || err_irq) break;
                    end else if (!throttle || $urandom_range(2) != 0) begin
                        if (exp_words.size() == 0)
                            chk(0, "R6", {tag, " extra word"}, out_rd_data, 0);
                        else begin
                            logic [63:0] e = exp_words.pop_front();
                            chk(out_rd_data == e, "R5", {tag, " word"}, out_rd_data, e);
                        end
                        out_rd_en = 1'b1;
                    end else out_rd_en = 1'b0;
                    @(negedge clk);
                end
            end
        join
        repeat (3) @(negedge clk);
        chk(exp_words.size() == 0, exp_err ? "R7" : "R6", {tag, " missing words"}, exp_words.size(), 0);
        chk(done_irq == !exp_err, "R6", {tag, " done_irq"}, done_irq, !exp_err);
        chk(err_irq == exp_err, "R7", {tag, " err_irq"}, err_irq, exp_err);
        chk(out_empty, "R8", {tag, " drained"}, out_empty, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk(out_empty, "R8", "reset out_empty", out_empty, 1);
        chk(!done_irq && !err_irq, "R10", "reset flags", {done_irq, err_irq}, 0);
        chk(in_dma_req, "R9", "reset in_dma_req", in_dma_req, 1);
        chk(!out_dma_req, "R9", "reset out_dma_req", out_dma_req, 0);

        // Input thresholds: decoder idle before first start, queue only fills
        in_dma_level = 4'd3;
        for (int k = 1; k <= 8; k++) begin
            in_wr_en = 1'b1;
            in_wr_data = 64'(k);
            @(negedge clk);
            in_wr_en = 1'b0;
            chk(in_dma_req == (k <= 3), "R9", "in_dma_req vs level", in_dma_req, k <= 3);
            chk(in_full == (k == 8), "R8", "in_full vs level", in_full, k == 8);
        end

        // R1 R2: 1-byte pixels, full window
        tok_cnt = '{2, 0, 4, 2};
        tok_val = '{64'h11, 64'h22, 64'h33, 64'h44};
        run_image("R2 8bpp", 4, 3, 0, 0, 3, 0, 2, 0, 0, 1);

        // R4: 3-byte pixels, inner window
        tok_cnt = '{6, 8, 3};
        tok_val = '{64'hA1B2C3, 64'h102030, 64'h0F0E0D};
        run_image("R4 24bpp window", 5, 4, 2, 1, 3, 1, 2, 0, 0, 1);

        // R3: 2-byte pixels, more output than queue depth, throttled reads
        tok_cnt = '{40, 0, 21};
        tok_val = '{64'hBEEF, 64'h1234, 64'hCAFE};
        run_image("R3 16bpp stall", 8, 8, 1, 0, 7, 0, 7, 0, 1, 1);

        // R1 R9: 4-byte pixels, single column, reads held until done
        tok_cnt = '{8};
        tok_val = '{64'hDEADBEEF};
        run_image("R1 32bpp hold", 3, 3, 3, 2, 2, 0, 2, 1, 0, 2);

        // R9: same, threshold above the level
        tok_cnt = '{8};
        tok_val = '{64'h01020304};
        run_image("R9 thr high", 3, 3, 3, 0, 2, 0, 2, 1, 0, 6);

        // R7: second run overruns; one full word out, partial word dropped
        tok_cnt = '{9, 9};
        tok_val = '{64'hAA, 64'hBB};
        run_image("R7 overrun", 4, 4, 0, 0, 3, 0, 3, 0, 0, 1);

        // R10 R4: fresh image after error, single pixel window
        tok_cnt = '{3};
        tok_val = '{64'h5A};
        run_image("R10 restart", 2, 2, 0, 0, 0, 1, 1, 0, 0, 1);

        // R6: trailing tokens beyond the image are not decoded
        tok_cnt = '{3, 5};
        tok_val = '{64'h77, 64'h99};
        run_image("R6 trailing", 2, 2, 0, 0, 1, 0, 1, 0, 1, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule